// File: doc/BRIEF.md
# FIFO-Level Interrupt Register Block

This block turns four FIFO level conditions from a data mover into one interrupt line for a host. The sources are read FIFO full, write FIFO empty, read FIFO half full and write FIFO half full. Each arrives as a level input. When a source goes from low to high, the block latches a pending bit in a status register. A per-source enable register masks the pending bits. A single global enable bit then gates the combined result before it reaches the registered interrupt output.

Software reaches the block over a plain 32-bit register port with an address, a write strobe, write data and combinational read data. A pending bit is cleared by writing a 1 to it. Writing a 1 inverts the bit, so the same write also sets a bit that was clear. A driver can therefore raise a pending bit by hand to test the interrupt path. The block does not produce the FIFO levels; they come in from outside.

Top module: `fifo_irq_regs`

## Requirements
- R1: After reset the global enable, status and enable registers all read zero and `irq_out` is low.
- R2: A write to offset 0x01C loads bit 31 of the write data into the global enable. Reading 0x01C returns that bit in position 31.
- R3: A write to offset 0x028 loads bits 3:0 into the enable register. A 1 enables the matching source and a 0 disables it. The register reads back at the same offset.
- R4: A write to offset 0x020 inverts every status bit whose write-data bit (3:0) is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R5: A low-to-high transition on `src_lvl[k]` sets status bit k one clock later. The bits are: bit 3 read FIFO full, bit 2 write FIFO empty, bit 1 read FIFO half full, bit 0 write FIFO half full. A source held high does not set its bit again after the bit has been cleared.
- R6: When a rising source edge and a status write that would invert the same bit occur in the same cycle, the bit ends up set. Other bits in that write still invert.
- R7: `irq_out` is a register. In each cycle it equals the global enable ANDed with the OR of (status AND enable) as they stood one cycle earlier.
- R8: Unused register bits read as zero and ignore writes: bits 31:4 of the status and enable registers, and bits 30:0 of the global enable register.
- R9: A read of any other offset returns zero. A write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| src_lvl | input | 4 | FIFO level conditions, one per status bit |
| irq_out | output | 1 | Registered interrupt request to the host |

## Verification
The checker watches several rules on every cycle. Each status bit must follow the invert-on-write rule, and a set edge must win over a same-cycle invert. The global enable and the status bits must hold when nothing writes them and no edge arrives. The interrupt output must follow the masked pending state one cycle later. Reserved and unmapped read data must stay zero. Only the directed scenarios can show that each source drives its own bit position and that a source held high never sets its bit again. They also show that the enable and global masks really suppress the line, and that writes to unmapped offsets leave the mapped registers untouched.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int NSRC   = 4;

    // source-to-bit positions, shared by status and enable registers
    localparam int SRC_WR_HALF  = 0;
    localparam int SRC_RD_HALF  = 1;
    localparam int SRC_WR_EMPTY = 2;
    localparam int SRC_RD_FULL  = 3;

    localparam logic [ADDR_W-1:0] OFF_GLB = 12'h01C;
    localparam logic [ADDR_W-1:0] OFF_PND = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_MSK = 12'h028;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_GLB,
        SEL_PND,
        SEL_MSK
    } reg_sel_e;
endpackage

// File: rtl/fifo_irq_dec.sv
module fifo_irq_dec
    import fifo_irq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel
);
    always_comb begin
        unique case (addr)
            AW'(OFF_GLB): sel = SEL_GLB;
            AW'(OFF_PND): sel = SEL_PND;
            AW'(OFF_MSK): sel = SEL_MSK;
            default:      sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/fifo_irq_edge.sv
module fifo_irq_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] lvl_d;

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= '0;
        else        lvl_d <= lvl;
    end

    assign rise = lvl & ~lvl_d;
endmodule

// File: rtl/fifo_irq_stat.sv
module fifo_irq_stat #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise,
    input  logic         pnd_wr,
    input  logic         msk_wr,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] pnd_q,
    output logic [N-1:0] msk_q,
    output logic         any_live
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                  bit_q <= 1'b0;
            else if (rise[i])            bit_q <= 1'b1;
            else if (pnd_wr && wbits[i]) bit_q <= ~bit_q;
        end
        assign pnd_q[i] = bit_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      msk_q <= '0;
        else if (msk_wr) msk_q <= wbits;
    end

    assign any_live = |(pnd_q & msk_q);
endmodule

// File: rtl/fifo_irq_regs.sv
module fifo_irq_regs
    import fifo_irq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NS = NSRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [NS-1:0] src_lvl,
    output logic          irq_out
);
    localparam int GLB_POS = DW - 1;

    reg_sel_e      sel;
    logic          glb_q;
    logic [NS-1:0] rise;
    logic [NS-1:0] pnd_q;
    logic [NS-1:0] msk_q;
    logic          any_live;
    logic          irq_q;

    fifo_irq_dec #(.AW(AW)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    fifo_irq_edge #(.N(NS)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (src_lvl),
        .rise  (rise)
    );

    fifo_irq_stat #(.N(NS)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .pnd_wr   (bus_we && sel == SEL_PND),
        .msk_wr   (bus_we && sel == SEL_MSK),
        .wbits    (bus_wdata[NS-1:0]),
        .pnd_q    (pnd_q),
        .msk_q    (msk_q),
        .any_live (any_live)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                         glb_q <= 1'b0;
        else if (bus_we && sel == SEL_GLB)  glb_q <= bus_wdata[GLB_POS];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= glb_q & any_live;
    end

    assign irq_out = irq_q;

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_GLB:  bus_rdata[GLB_POS]  = glb_q;
            SEL_PND:  bus_rdata[NS-1:0]   = pnd_q;
            SEL_MSK:  bus_rdata[NS-1:0]   = msk_q;
            default:  bus_rdata           = '0;
        endcase
    end
endmodule

// File: rtl/fifo_irq_regs_chk.sv
module fifo_irq_regs_chk
    import fifo_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NSRC-1:0]   src_lvl,
    input logic              irq_out,
    input logic              glb_q,
    input logic [NSRC-1:0]   pnd_q,
    input logic [NSRC-1:0]   msk_q
);
    logic [NSRC-1:0] src_prev;
    logic [NSRC-1:0] edge_c;
    logic            pnd_hit;
    logic            glb_hit;
    logic            mapped;

    always_ff @(posedge clk) begin
        if (!rst_n) src_prev <= '0;
        else        src_prev <= src_lvl;
    end

    assign edge_c  = src_lvl & ~src_prev;
    assign pnd_hit = bus_we && bus_addr == OFF_PND;
    assign glb_hit = bus_we && bus_addr == OFF_GLB;
    assign mapped  = bus_addr == OFF_GLB || bus_addr == OFF_PND || bus_addr == OFF_MSK;

    // R4: invert-on-write when no edge competes
    a_r4_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (pnd_hit && edge_c == '0) |=> pnd_q == ($past(pnd_q) ^ $past(bus_wdata[NSRC-1:0])));

    // R6: an edge always leaves its bit set
    a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_c != '0) |=> ((pnd_q & $past(edge_c)) == $past(edge_c)));

    // R5: no write and no edge keeps status
    a_r5_pnd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pnd_hit && edge_c == '0) |=> $stable(pnd_q));

    // R2: global enable only changes by a write at its offset
    a_r2_glb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_hit |=> $stable(glb_q));

    // R7: output lags the masked pending state by one cycle
    a_r7_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_out == ($past(glb_q) && ($past(pnd_q & msk_q) != '0)));

    // R8: reserved read bits stay zero
    a_r8_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-2:NSRC] == '0);

    // R9: unmapped offsets read zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> bus_rdata == '0);
endmodule

bind fifo_irq_regs fifo_irq_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_lvl   (src_lvl),
    .irq_out   (irq_out),
    .glb_q     (glb_q),
    .pnd_q     (pnd_q),
    .msk_q     (msk_q)
);

// File: tb/fifo_irq_regs_bench.sv
module fifo_irq_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_lvl = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [11:0] A_GLB = 12'h01C;
    localparam logic [11:0] A_PND = 12'h020;
    localparam logic [11:0] A_MSK = 12'h028;

    always #10 clk = ~clk;

    fifo_irq_regs u_fifo_irq_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_lvl   (src_lvl),
        .irq_out   (irq_out)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we = 1'b0; src_lvl = '0; bus_wdata = '0; bus_addr = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(bus_rdata, exp, tag);
    endtask

    task automatic t_reset();
        do_reset();
        check({31'b0, irq_out}, 32'h0, "R1 irq after reset");
        rd(A_GLB, 32'h0, "R1 global after reset");
        rd(A_PND, 32'h0, "R1 status after reset");
        rd(A_MSK, 32'h0, "R1 enable after reset");
    endtask

    task automatic t_global();
        do_reset();
        wr(A_GLB, 32'hFFFF_FFFF);
        rd(A_GLB, 32'h8000_0000, "R2 R8 global set, low bits zero");
        wr(A_GLB, 32'h7FFF_FFFF);
        rd(A_GLB, 32'h0, "R2 global cleared by bit31=0");
    endtask

    task automatic t_enable();
        do_reset();
        wr(A_MSK, 32'hFFFF_FFFA);
        rd(A_MSK, 32'h0000_000A, "R3 R8 enable load");
        wr(A_MSK, 32'h5);
        rd(A_MSK, 32'h5, "R3 enable disable/enable");
    endtask

    task automatic t_toggle();
        do_reset();
        wr(A_PND, 32'h6);
        rd(A_PND, 32'h6, "R4 invert from zero");
        wr(A_PND, 32'h5);
        rd(A_PND, 32'h3, "R4 invert mixed");
        wr(A_PND, 32'h0);
        rd(A_PND, 32'h3, "R4 zero write no change");
        wr(A_PND, 32'hFFFF_FFF0);
        rd(A_PND, 32'h3, "R8 upper write bits ignored");
    endtask

    task automatic t_edge();
        do_reset();
        @(negedge clk); src_lvl = 4'b1000;
        @(negedge clk);
        rd(A_PND, 32'h8, "R5 read-full edge sets bit3");
        wr(A_PND, 32'h8);
        repeat (2) @(negedge clk);
        rd(A_PND, 32'h0, "R5 held level does not re-set");
        src_lvl = 4'b0010;
        @(negedge clk);
        rd(A_PND, 32'h2, "R5 read-half edge sets bit1");
        src_lvl = 4'b0111;
        @(negedge clk);
        rd(A_PND, 32'h7, "R5 write-half and write-empty set bits 0 and 2");
    endtask

    task automatic t_set_wins();
        do_reset();
        @(negedge clk); src_lvl = 4'b0001;
        @(negedge clk); src_lvl = 4'b0000;
        @(negedge clk);
        rd(A_PND, 32'h1, "R6 setup bit0 set");
        src_lvl = 4'b0001; bus_addr = A_PND; bus_we = 1'b1; bus_wdata = 32'h3;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        rd(A_PND, 32'h3, "R6 edge beats invert, bit1 still inverts");
    endtask

    task automatic t_irq();
        do_reset();
        wr(A_MSK, 32'h4);
        wr(A_PND, 32'h4);
        @(negedge clk);
        check({31'b0, irq_out}, 32'h0, "R7 global off masks irq");
        wr(A_GLB, 32'h8000_0000);
        check({31'b0, irq_out}, 32'h0, "R7 irq lags global by a cycle");
        @(negedge clk);
        check({31'b0, irq_out}, 32'h1, "R7 irq asserted");
        wr(A_PND, 32'h6);
        check({31'b0, irq_out}, 32'h1, "R7 irq lags status clear");
        @(negedge clk);
        check({31'b0, irq_out}, 32'h0, "R7 disabled source bit1 does not drive irq");
    endtask

    task automatic t_unmapped();
        do_reset();
        wr(12'h024, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        wr(12'h02C, 32'hFFFF_FFFF);
        rd(12'h024, 32'h0, "R9 read of 0x024");
        rd(12'h02C, 32'h0, "R9 read of 0x02C");
        rd(A_GLB, 32'h0, "R9 global untouched");
        rd(A_PND, 32'h0, "R9 status untouched");
        rd(A_MSK, 32'h0, "R9 enable untouched");
        check({31'b0, irq_out}, 32'h0, "R9 irq untouched");
    endtask

    initial begin
        t_reset();
        t_global();
        t_enable();
        t_toggle();
        t_edge();
        t_set_wins();
        t_irq();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule